// File: doc/BRIEF.md
# Powerdown Entry and Recovery Sequencer

This block decides when a processor core may enter its deepest low-power state and how it comes back out. A rising edge on the external powerdown pin, or a rising edge on a force bit that software controls, raises a one-cycle non-maskable interrupt. The core keeps running so that software can run as many instructions as it needs. When software has finished its housekeeping it pulses a commit strobe. At that strobe the sequencer stops the core clock, raises an acknowledge output and, in crystal mode, turns the oscillator off.

A later rising edge on the pin starts recovery. The acknowledge output drops at once and the oscillator is re-enabled. A counter then waits a long interval if the crystal had been stopped, or a short interval if the clock had kept running. The core clock is released on the cycle that counter reaches zero. The option chosen at entry, which is either to resume the saved context or to start clean, is presented to the core. An asynchronous reset ends any of these phases and returns the block to normal running with a clean context.

Top module: `pd_sequencer`

## Requirements
- R1: While reset is held and after it is released with no request, pdAck=0, oscOff=0, pdIrq=0, ctxRestore=0 and coreClkEn=1.
- R2: In the running state, a rising edge on pdPin or swForce that is sampled at a clock edge makes pdIrq high for exactly the following cycle. The block moves to a pending state in which coreClkEn stays 1 and pdAck stays 0.
- R3: A request input held high does not trigger again. Request edges that arrive while an entry is pending produce no further pdIrq.
- R4: A commit pulse sampled while pending makes pdAck=1 and coreClkEn=0 from the next cycle. A commit pulse in any other state has no effect.
- R5: xtalMode and keepCtx are sampled at the commit edge (xtalMode 1 = crystal, oscillator stopped). During powerdown oscOff=1 only if xtalMode was 1 at commit, and later changes of xtalMode have no effect.
- R6: In powerdown, swForce edges and commit are ignored. A rising pdPin edge starts recovery, and from the next cycle pdAck=0 and oscOff=0 while coreClkEn stays 0.
- R7: In crystal mode, coreClkEn returns to 1 exactly XTAL_WAIT (default 4096) clock edges after the edge that sampled the wake-up rise.
- R8: In running-oscillator mode (xtalMode 0 at commit), coreClkEn returns to 1 exactly RUN_WAIT (default 100) clock edges after the edge that sampled the wake-up rise.
- R9: pdPin and swForce edges during recovery have no effect on its length and raise no pdIrq.
- R10: ctxRestore takes the keepCtx value sampled at commit (1 = resume saved context, 0 = clean start) and holds it through recovery and afterwards until the next commit or reset.
- R11: Reset asserted during powerdown or recovery immediately gives coreClkEn=1, pdAck=0, oscOff=0 and ctxRestore=0, and recovery does not continue after reset is released.
- R12: After a completed recovery the block accepts a new request and can enter powerdown again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pdPin | input | 1 | External powerdown pin; a rising edge requests entry or wake-up |
| swForce | input | 1 | Software force bit; a rising edge requests entry |
| commit | input | 1 | Software strobe that commits a pending entry |
| xtalMode | input | 1 | 1 = crystal stopped during powerdown, 0 = clock keeps running |
| keepCtx | input | 1 | 1 = resume saved context on exit, 0 = clean start |
| pdIrq | output | 1 | One-cycle non-maskable powerdown interrupt |
| pdAck | output | 1 | High while the powerdown state is held |
| oscOff | output | 1 | Oscillator disable |
| coreClkEn | output | 1 | Core clock gate enable |
| ctxRestore | output | 1 | Context choice presented to the core |

## Verification
The hardest condition to reach from the ports is a reset that lands in the middle of a long crystal recovery, together with proof that the count does not resume afterwards. The stimulus commits in crystal mode, wakes the block, waits a few hundred cycles into the 4096-cycle count and then pulses reset. The cycle model is compared on every clock after that, so any leftover counting or stale context shows up as a mismatch. Earlier in the run, wake and force edges are injected while recovery is under way, and xtalMode is toggled during powerdown, to show that these inputs are ignored.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

  typedef enum logic [1:0] {
    ST_RUN        = 2'd0,
    ST_ENTER_PEND = 2'd1,
    ST_POWERDOWN  = 2'd2,
    ST_RECOVER    = 2'd3
  } pd_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCfg;  // capture clock mode and context choice
    logic loadCnt;   // load the recovery counter
    logic countEn;   // decrement the recovery counter
  } pd_strobe_t;

endpackage

// File: rtl/pd_seq_datapath.sv
module pd_seq_datapath
  import pd_seq_pkg::*;
#(
  parameter int XTAL_WAIT = 4096,
  parameter int RUN_WAIT  = 100,
  parameter int CNT_W     = 13
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pdPin,
  input  logic       swForce,
  input  logic       xtalMode,
  input  logic       keepCtx,
  input  pd_strobe_t strobe,
  output logic       pinRise,
  output logic       forceRise,
  output logic       cntZero,
  output logic       xtalLatched,
  output logic       ctxRestore
);

  localparam int NUM_SRC = 2;
  localparam logic [CNT_W-1:0] LOAD_XTAL = CNT_W'(XTAL_WAIT);
  localparam logic [CNT_W-1:0] LOAD_RUN  = CNT_W'(RUN_WAIT);

  logic [NUM_SRC-1:0] reqIn;
  logic [NUM_SRC-1:0] reqQ;
  logic [NUM_SRC-1:0] reqRise;
  logic [CNT_W-1:0]   waitCnt;

  assign reqIn = {swForce, pdPin};

  // one edge detector per request source
  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_edge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) reqQ[gi] <= 1'b0;
      else       reqQ[gi] <= reqIn[gi];
    end
    assign reqRise[gi] = reqIn[gi] & ~reqQ[gi];
  end

  assign pinRise   = reqRise[0];
  assign forceRise = reqRise[1];

  // configuration captured at commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xtalLatched <= 1'b0;
      ctxRestore  <= 1'b0;
    end else if (strobe.latchCfg) begin
      xtalLatched <= xtalMode;
      ctxRestore  <= keepCtx;
    end
  end

  // recovery wait counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strobe.loadCnt) begin
      waitCnt <= xtalLatched ? LOAD_XTAL : LOAD_RUN;
    end else if (strobe.countEn && (waitCnt != '0)) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  assign cntZero = (waitCnt == '0);

endmodule

// File: rtl/pd_seq_ctrl.sv
module pd_seq_ctrl
  import pd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinRise,
  input  logic       forceRise,
  input  logic       commit,
  input  logic       cntZero,
  input  logic       xtalLatched,
  output pd_strobe_t strobe,
  output logic       pdIrq,
  output logic       pdAck,
  output logic       oscOff,
  output logic       coreClkEn
);

  pd_state_e state;
  pd_state_e stateNext;
  logic      irqNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    irqNext   = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (pinRise || forceRise) begin
          stateNext = ST_ENTER_PEND;
          irqNext   = 1'b1;
        end
      end
      ST_ENTER_PEND: begin
        if (commit) begin
          stateNext       = ST_POWERDOWN;
          strobe.latchCfg = 1'b1;
        end
      end
      ST_POWERDOWN: begin
        if (pinRise) begin
          stateNext      = ST_RECOVER;
          strobe.loadCnt = 1'b1;
        end
      end
      ST_RECOVER: begin
        strobe.countEn = 1'b1;
        if (cntZero) stateNext = ST_RUN;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RUN;
      pdIrq <= 1'b0;
    end else begin
      state <= stateNext;
      pdIrq <= irqNext;
    end
  end

  assign pdAck     = (state == ST_POWERDOWN);
  assign oscOff    = (state == ST_POWERDOWN) && xtalLatched;
  assign coreClkEn = (state == ST_RUN) || (state == ST_ENTER_PEND) ||
                     ((state == ST_RECOVER) && cntZero);

endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
  import pd_seq_pkg::*;
#(
  parameter int XTAL_WAIT = 4096,
  parameter int RUN_WAIT  = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic pdPin,
  input  logic swForce,
  input  logic commit,
  input  logic xtalMode,
  input  logic keepCtx,
  output logic pdIrq,
  output logic pdAck,
  output logic oscOff,
  output logic coreClkEn,
  output logic ctxRestore
);

  localparam int MAX_WAIT = (XTAL_WAIT > RUN_WAIT) ? XTAL_WAIT : RUN_WAIT;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  pd_strobe_t strobe;
  logic       pinRise;
  logic       forceRise;
  logic       cntZero;
  logic       xtalLatched;

  pd_seq_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .pinRise    (pinRise),
    .forceRise  (forceRise),
    .commit     (commit),
    .cntZero    (cntZero),
    .xtalLatched(xtalLatched),
    .strobe     (strobe),
    .pdIrq      (pdIrq),
    .pdAck      (pdAck),
    .oscOff     (oscOff),
    .coreClkEn  (coreClkEn)
  );

  pd_seq_datapath #(
    .XTAL_WAIT(XTAL_WAIT),
    .RUN_WAIT (RUN_WAIT),
    .CNT_W    (CNT_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .pdPin      (pdPin),
    .swForce    (swForce),
    .xtalMode   (xtalMode),
    .keepCtx    (keepCtx),
    .strobe     (strobe),
    .pinRise    (pinRise),
    .forceRise  (forceRise),
    .cntZero    (cntZero),
    .xtalLatched(xtalLatched),
    .ctxRestore (ctxRestore)
  );

endmodule

// File: rtl/pd_seq_checker.sv
module pd_seq_checker #(
  parameter int XTAL_WAIT = 4096,
  parameter int RUN_WAIT  = 100
) (
  input logic clk,
  input logic rstN,
  input logic pdIrq,
  input logic pdAck,
  input logic oscOff,
  input logic coreClkEn,
  input logic ctxRestore
);

  logic [31:0] recCnt;
  logic        xtalSeen;

  // counts gated cycles after acknowledge drops; mode remembered from oscOff
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recCnt   <= '0;
      xtalSeen <= 1'b0;
    end else if (pdAck) begin
      recCnt   <= '0;
      xtalSeen <= oscOff;
    end else if (!coreClkEn) begin
      recCnt <= recCnt + 1;
    end
  end

  p_ack_gates_clock_r4: assert property (@(posedge clk) disable iff (!rstN)
    pdAck |-> !coreClkEn);

  p_irq_one_cycle_r2: assert property (@(posedge clk) disable iff (!rstN)
    pdIrq |=> !pdIrq);

  p_irq_while_running_r2: assert property (@(posedge clk) disable iff (!rstN)
    pdIrq |-> (coreClkEn && !pdAck));

  p_osc_only_in_pd_r5: assert property (@(posedge clk) disable iff (!rstN)
    oscOff |-> pdAck);

  p_wake_keeps_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pdAck) |-> (!coreClkEn && !oscOff));

  p_recover_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(coreClkEn) && xtalSeen) |-> (recCnt == 32'(XTAL_WAIT)));

  p_recover_len_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(coreClkEn) && !xtalSeen) |-> (recCnt == 32'(RUN_WAIT)));

  p_ctx_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(pdAck) |-> $stable(ctxRestore));

endmodule

bind pd_sequencer pd_seq_checker #(
  .XTAL_WAIT(XTAL_WAIT),
  .RUN_WAIT (RUN_WAIT)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .pdIrq     (pdIrq),
  .pdAck     (pdAck),
  .oscOff    (oscOff),
  .coreClkEn (coreClkEn),
  .ctxRestore(ctxRestore)
);

// File: tb/pd_sequencer_tb.sv
module pd_sequencer_tb_top;

  localparam int XW = 4096;
  localparam int RW = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pdPin = 1'b0;
  logic swForce = 1'b0;
  logic commit = 1'b0;
  logic xtalMode = 1'b0;
  logic keepCtx = 1'b0;
  logic pdIrq, pdAck, oscOff, coreClkEn, ctxRestore;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string curReq = "R1";

  always #10 clk = ~clk;

  pd_sequencer #(.XTAL_WAIT(XW), .RUN_WAIT(RW)) dut_i (
    .clk(clk), .rstN(rstN), .pdPin(pdPin), .swForce(swForce),
    .commit(commit), .xtalMode(xtalMode), .keepCtx(keepCtx),
    .pdIrq(pdIrq), .pdAck(pdAck), .oscOff(oscOff),
    .coreClkEn(coreClkEn), .ctxRestore(ctxRestore)
  );

  // behavioural reference: phase 0 run, 1 pending, 2 down, 3 waking
  int  mPhase = 0;
  int  mLeft = 0;
  bit  mXtal = 0, mCtx = 0, mIrq = 0, mPin = 0, mForce = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mLeft = 0; mXtal = 0; mCtx = 0; mIrq = 0; mPin = 0; mForce = 0;
    end else begin
      bit pr, fr;
      pr = pdPin && !mPin;
      fr = swForce && !mForce;
      mIrq = 0;
      if (mPhase == 0) begin
        if (pr || fr) begin mPhase = 1; mIrq = 1; end
      end else if (mPhase == 1) begin
        if (commit) begin mPhase = 2; mXtal = xtalMode; mCtx = keepCtx; end
      end else if (mPhase == 2) begin
        if (pr) begin mPhase = 3; mLeft = mXtal ? XW : RW; end
      end else begin
        if (mLeft == 0) mPhase = 0;
        else mLeft = mLeft - 1;
      end
      mPin = pdPin;
      mForce = swForce;
    end
  end

  task automatic compare();
    logic [4:0] exp, act;
    exp = {mIrq, mPhase == 2, (mPhase == 2) && mXtal,
           (mPhase < 2) || (mPhase == 3 && mLeft == 0), mCtx};
    act = {pdIrq, pdAck, oscOff, coreClkEn, ctxRestore};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t {irq,ack,oscOff,clkEn,ctx} actual=%b expected=%b",
               curReq, $time, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare();
    end
  endtask

  // measure edges from the wake sample to clock release
  task automatic measure_wake(int expect_n, string tag);
    int cnt = 0;
    pdPin = 1'b1;
    @(posedge clk);
    @(negedge clk);
    compare();
    while (!coreClkEn && cnt < XW + 10) begin
      @(posedge clk);
      @(negedge clk);
      compare();
      cnt++;
    end
    checks++;
    if (cnt != expect_n) begin
      fails++;
      $display("FAIL %s recovery edges actual=%0d expected=%0d", tag, cnt, expect_n);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired in %s", curReq);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    curReq = "R1";
    @(negedge clk); compare();
    tick(2);
    rstN = 1'b1;
    tick(3);

    // R4 commit while running is ignored
    curReq = "R4";
    commit = 1'b1; tick(1); commit = 1'b0; tick(2);

    // R2 pin edge gives interrupt, pending keeps clock
    curReq = "R2";
    pdPin = 1'b1; tick(4);
    // R3 held pin and force edge while pending ignored
    curReq = "R3";
    swForce = 1'b1; tick(2); swForce = 1'b0; tick(20);

    // R4 and R5: commit in running-clock mode, keep context
    curReq = "R4";
    xtalMode = 1'b0; keepCtx = 1'b1;
    commit = 1'b1; tick(1); commit = 1'b0; xtalMode = 1'b1; keepCtx = 1'b0; tick(3);
    curReq = "R5";
    tick(5);
    // R6 force edge and commit during powerdown ignored
    curReq = "R6";
    swForce = 1'b1; tick(2); swForce = 1'b0; commit = 1'b1; tick(1); commit = 1'b0;
    pdPin = 1'b0; tick(3);

    // R8 short recovery, with R9 noise not possible inside measure; check length
    curReq = "R8";
    measure_wake(RW, "R8");
    curReq = "R10";
    tick(4);

    // R12 re-enter via force bit, crystal mode, clean context
    curReq = "R12";
    pdPin = 1'b0; swForce = 1'b1; tick(3); swForce = 1'b0;
    xtalMode = 1'b1; keepCtx = 1'b0;
    commit = 1'b1; tick(1); commit = 1'b0; xtalMode = 1'b0;
    curReq = "R5";
    tick(4);
    // R9 wake, then edges during recovery must not change its length
    curReq = "R9";
    pdPin = 1'b1; tick(1);
    pdPin = 1'b0; tick(5); pdPin = 1'b1; swForce = 1'b1; tick(3);
    pdPin = 1'b0; swForce = 1'b0;
    curReq = "R7";
    tick(XW);
    tick(3);
    curReq = "R10";
    tick(2);

    // R7 measured crystal recovery
    curReq = "R7";
    swForce = 1'b1; tick(2); swForce = 1'b0;
    xtalMode = 1'b1; keepCtx = 1'b1;
    commit = 1'b1; tick(1); commit = 1'b0; tick(3);
    measure_wake(XW, "R7");
    pdPin = 1'b0; tick(3);

    // R11 reset in the middle of a crystal recovery
    curReq = "R11";
    pdPin = 1'b1; tick(2); pdPin = 1'b0;
    commit = 1'b1; tick(1); commit = 1'b0; tick(3);
    pdPin = 1'b1; tick(300);
    rstN = 1'b0; #1; compare(); tick(2);
    rstN = 1'b1; pdPin = 1'b0; tick(XW + 20);

    // R11 reset while held in powerdown, context choice cleared
    pdPin = 1'b1; tick(2); pdPin = 1'b0;
    keepCtx = 1'b1; commit = 1'b1; tick(1); commit = 1'b0; tick(5);
    rstN = 1'b0; #1; compare(); tick(2);
    rstN = 1'b1; tick(5);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule